// File: doc/BRIEF.md
# Single-Operand ALU with Flags

This block is the data path for the one-operand arithmetic, shift and rotate group of a 16-bit minicomputer-style instruction set. It is purely combinational. The instruction word, the fetched operand and the current condition flags go in. The write-back value, the next condition flags and a write enable come out in the same cycle. Fetching the operand, resolving the addressing mode and storing the result are handled by the surrounding core.

A byte/word select bit in the instruction picks the data width. In byte mode only the low half of the operand is processed. The upper half is handed back untouched, and the sign, overflow and carry boundaries move to the byte. Each operation has its own rule for each flag: the flag is forced, kept, or computed from the result. The rules are listed below. Two operations exist only in word form. Any instruction the block does not own is returned as a no-op: no write, and the flags are unchanged.

Top module: `sop_alu`

## Requirements
- R1: The operation code is instruction bits 14..6, read as three octal digits. 050..063 select, in order, clear, complement, increment, decrement, negate, add carry, subtract carry, test, rotate right, rotate left, shift right and shift left. 003 selects swap bytes and 067 selects sign extend. Bits 5..0 are ignored. Any other code gives wr_en=0, result=operand and flags_out=flags_in.
- R2: Instruction bit 15 = 1 selects byte mode. In byte mode, result bits 15..8 equal operand bits 15..8, N is taken from bit 7, and the overflow and carry boundaries are 0x7F/0x80 and 0xFF/0x00.
- R3: Clear writes 0 and gives NZVC = 0100. Flags are packed as [3]=N, [2]=Z, [1]=V, [0]=C.
- R4: Complement writes the bitwise NOT of the operand, sets V=0 and C=1, and computes N and Z from the result.
- R5: Increment and decrement write operand+1 and operand-1. V is set only when the operand is the largest positive value (increment) or the most negative value (decrement). C is kept.
- R6: Negate writes the two's complement. C=1 unless the result is zero. V=1 only when the result is the most negative value.
- R7: Add carry writes operand+C. V is set when C=1 and the operand is the largest positive value, and C is set when C=1 and the operand is all ones. Subtract carry writes operand-C. V is set when C=1 and the operand is the most negative value, and C is set when C=1 and the operand is zero.
- R8: Test writes nothing (wr_en=0, result=operand). It computes N and Z from the operand and clears V and C.
- R9: Rotate right and rotate left move the bits through C as a ring of width+1 bits. C receives the bit shifted out.
- R10: Shift right keeps the sign bit. Shift left fills with 0. C receives the bit shifted out.
- R11: For all four shift and rotate operations, the new V equals the new N XOR the new C.
- R12: Swap bytes exchanges the two halves. N and Z come from the low byte of the result. V and C are cleared.
- R13: Sign extend writes all ones when the incoming N is 1, and 0 otherwise. Z is computed from the result, V=0, and N and C are kept.
- R14: Swap bytes and sign extend exist only in word form. With bit 15 set, codes 003 and 067 are treated as codes the block does not own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word: byte select in bit 15, operation code in bits 14..6 |
| operand | input | 16 | Destination operand value |
| flags_in | input | 4 | Current N, Z, V, C flags |
| result | output | 16 | Value to write back |
| flags_out | output | 4 | Next N, Z, V, C flags |
| wr_en | output | 1 | Write the result back to the destination |

## Verification
The hardest cases to reach are the overflow and carry corners that depend on the incoming carry. Examples are add carry on the largest positive value and subtract carry on the most negative value, and the byte-mode copies of these corners with a non-zero upper byte that must survive. Nothing inside the block holds state, so the stimulus reaches each corner in one step by setting flags_in directly next to the boundary operand. Each corner is paired with the same operand and the carry cleared. The word-only codes are also driven with the byte bit set, to confirm they fall back to a no-op.

// File: rtl/sop_alu_pkg.sv
package sop_alu_pkg;

    localparam int INSTR_W = 16;
    localparam int CODE_W  = 9;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLR,
        OP_COM,
        OP_INC,
        OP_DEC,
        OP_NEG,
        OP_ADC,
        OP_SBC,
        OP_TST,
        OP_ROR,
        OP_ROL,
        OP_ASR,
        OP_ASL,
        OP_SWAB,
        OP_SXT
    } sop_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/sop_decode.sv
module sop_decode
    import sop_alu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output sop_e               op,
    output logic               byte_mode
);

    logic [CODE_W-1:0] code;

    assign code      = instr[14:6];
    assign byte_mode = instr[15];

    always_comb begin
        case (code)
            9'o050:  op = OP_CLR;
            9'o051:  op = OP_COM;
            9'o052:  op = OP_INC;
            9'o053:  op = OP_DEC;
            9'o054:  op = OP_NEG;
            9'o055:  op = OP_ADC;
            9'o056:  op = OP_SBC;
            9'o057:  op = OP_TST;
            9'o060:  op = OP_ROR;
            9'o061:  op = OP_ROL;
            9'o062:  op = OP_ASR;
            9'o063:  op = OP_ASL;
            9'o003:  op = instr[15] ? OP_NONE : OP_SWAB;
            9'o067:  op = instr[15] ? OP_NONE : OP_SXT;
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/sop_arith.sv
module sop_arith
    import sop_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  sop_e         op,
    input  logic [W-1:0] d,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         v,
    output logic         c
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};
    localparam logic [W-1:0] ZERO    = '0;
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cin_w;
    assign cin_w = {{(W-1){1'b0}}, cin};

    always_comb begin
        r = d;
        v = 1'b0;
        c = 1'b0;
        unique case (op)
            OP_CLR: begin
                r = ZERO;
            end
            OP_COM: begin
                r = ~d;
                c = 1'b1;
            end
            OP_INC: begin
                r = d + ONE;
                v = (d == MAX_POS);
            end
            OP_DEC: begin
                r = d - ONE;
                v = (d == MIN_NEG);
            end
            OP_NEG: begin
                r = ZERO - d;
                v = (r == MIN_NEG);
                c = (r != ZERO);
            end
            OP_ADC: begin
                r = d + cin_w;
                v = cin && (d == MAX_POS);
                c = cin && (d == ALL_ONE);
            end
            OP_SBC: begin
                r = d - cin_w;
                v = cin && (d == MIN_NEG);
                c = cin && (d == ZERO);
            end
            default: begin
                r = d;
            end
        endcase
    end

endmodule

// File: rtl/sop_shift.sv
module sop_shift
    import sop_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  sop_e         op,
    input  logic [W-1:0] d,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         v,
    output logic         c
);

    always_comb begin
        r = d;
        c = 1'b0;
        unique case (op)
            OP_ROR: begin
                r = {cin, d[W-1:1]};
                c = d[0];
            end
            OP_ROL: begin
                r = {d[W-2:0], cin};
                c = d[W-1];
            end
            OP_ASR: begin
                r = {d[W-1], d[W-1:1]};
                c = d[0];
            end
            OP_ASL: begin
                r = {d[W-2:0], 1'b0};
                c = d[W-1];
            end
            default: begin
                r = d;
            end
        endcase
        v = r[W-1] ^ c;
    end

endmodule

// File: rtl/sop_swap.sv
module sop_swap
    import sop_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  sop_e         op,
    input  logic [W-1:0] d,
    input  logic         nin,
    output logic [W-1:0] r
);

    localparam int HALF = W / 2;

    always_comb begin
        unique case (op)
            OP_SWAB: r = {d[HALF-1:0], d[W-1:HALF]};
            OP_SXT:  r = {W{nin}};
            default: r = d;
        endcase
    end

endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  operand,
    input  logic [3:0]         flags_in,
    output logic [DATA_W-1:0]  result,
    output logic [3:0]         flags_out,
    output logic               wr_en
);

    localparam int HALF    = DATA_W / 2;
    localparam int N_LANES = 2;

    sop_e  op;
    logic  byte_mode;
    nzvc_t fin;
    nzvc_t fout;

    assign fin = nzvc_t'(flags_in);

    sop_decode u_dec (
        .instr     (instr),
        .op        (op),
        .byte_mode (byte_mode)
    );

    // Lane 0 works at full width, lane 1 on the low half.
    logic [DATA_W-1:0] a_r [N_LANES];
    logic              a_v [N_LANES];
    logic              a_c [N_LANES];
    logic [DATA_W-1:0] s_r [N_LANES];
    logic              s_v [N_LANES];
    logic              s_c [N_LANES];
    logic              l_n [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? DATA_W : HALF;
        logic [LW-1:0] ld;
        logic [LW-1:0] ar;
        logic [LW-1:0] sr;

        assign ld = operand[LW-1:0];

        sop_arith #(.W(LW)) u_arith (
            .op  (op),
            .d   (ld),
            .cin (fin.c),
            .r   (ar),
            .v   (a_v[g]),
            .c   (a_c[g])
        );

        sop_shift #(.W(LW)) u_shift (
            .op  (op),
            .d   (ld),
            .cin (fin.c),
            .r   (sr),
            .v   (s_v[g]),
            .c   (s_c[g])
        );

        assign a_r[g] = DATA_W'(ar);
        assign s_r[g] = DATA_W'(sr);
        assign l_n[g] = (op == OP_ASR || op == OP_ASL || op == OP_ROR || op == OP_ROL)
                        ? sr[LW-1] : ar[LW-1];
    end

    logic [DATA_W-1:0] w_r;

    sop_swap #(.W(DATA_W)) u_swap (
        .op  (op),
        .d   (operand),
        .nin (fin.n),
        .r   (w_r)
    );

    int unsigned       ln;
    logic [DATA_W-1:0] lane_r;
    logic              lane_z;

    always_comb begin
        ln = byte_mode ? 1 : 0;
        unique case (op)
            OP_ROR, OP_ROL, OP_ASR, OP_ASL: lane_r = s_r[ln];
            default:                        lane_r = a_r[ln];
        endcase
        lane_z = byte_mode ? (lane_r[HALF-1:0] == '0) : (lane_r == '0);
    end

    always_comb begin
        result = operand;
        fout   = fin;
        wr_en  = 1'b0;
        unique case (op)
            OP_NONE: begin
                result = operand;
            end
            OP_CLR, OP_COM, OP_NEG, OP_ADC, OP_SBC: begin
                result = byte_mode ? {operand[DATA_W-1:HALF], lane_r[HALF-1:0]} : lane_r;
                fout   = '{n: l_n[ln], z: lane_z, v: a_v[ln], c: a_c[ln]};
                wr_en  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                result = byte_mode ? {operand[DATA_W-1:HALF], lane_r[HALF-1:0]} : lane_r;
                fout   = '{n: l_n[ln], z: lane_z, v: a_v[ln], c: fin.c};
                wr_en  = 1'b1;
            end
            OP_TST: begin
                result = operand;
                fout   = '{n: l_n[ln], z: lane_z, v: 1'b0, c: 1'b0};
            end
            OP_ROR, OP_ROL, OP_ASR, OP_ASL: begin
                result = byte_mode ? {operand[DATA_W-1:HALF], lane_r[HALF-1:0]} : lane_r;
                fout   = '{n: l_n[ln], z: lane_z, v: s_v[ln], c: s_c[ln]};
                wr_en  = 1'b1;
            end
            OP_SWAB: begin
                result = w_r;
                fout   = '{n: w_r[HALF-1], z: (w_r[HALF-1:0] == '0), v: 1'b0, c: 1'b0};
                wr_en  = 1'b1;
            end
            OP_SXT: begin
                result = w_r;
                fout   = '{n: fin.n, z: (w_r == '0), v: 1'b0, c: fin.c};
                wr_en  = 1'b1;
            end
            default: begin
                result = operand;
            end
        endcase
    end

    assign flags_out = fout;

endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk #(
    parameter int DATA_W = 16
) (
    input logic [15:0]       instr,
    input logic [DATA_W-1:0] operand,
    input logic [3:0]        flags_in,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        flags_out,
    input logic              wr_en
);

    localparam int HALF = DATA_W / 2;

    logic [8:0] code;
    logic       owned;

    assign code  = instr[14:6];
    assign owned = (code >= 9'o050 && code <= 9'o063) ||
                   (!instr[15] && (code == 9'o003 || code == 9'o067));

    always_comb begin
        if (!$isunknown({instr, operand, flags_in})) begin
            // R1 and R14: codes the block does not own behave as a no-op
            p_foreign_noop_r1: assert (owned || (!wr_en && flags_out == flags_in && result == operand))
                else $error("foreign code altered state");
            // R2: byte mode keeps the upper half
            p_upper_kept_r2: assert (!(owned && instr[15]) || result[DATA_W-1:HALF] == operand[DATA_W-1:HALF])
                else $error("upper byte changed in byte mode");
            // R3
            p_clr_flags_r3: assert (code != 9'o050 || (flags_out == 4'b0100 && result[HALF-1:0] == '0))
                else $error("clear flags wrong");
            // R5
            p_incdec_keep_c_r5: assert (!(code == 9'o052 || code == 9'o053) || flags_out[0] == flags_in[0])
                else $error("carry not kept");
            // R8
            p_tst_no_write_r8: assert (code != 9'o057 || (!wr_en && result == operand))
                else $error("test wrote a result");
            // R11
            p_shift_v_r11: assert (!(code >= 9'o060 && code <= 9'o063) ||
                                   flags_out[1] == (flags_out[3] ^ flags_out[0]))
                else $error("shift overflow rule broken");
            // R13
            p_sxt_fill_r13: assert (!(code == 9'o067 && !instr[15]) || result == {DATA_W{flags_in[3]}})
                else $error("sign extend fill wrong");
        end
    end

endmodule

bind sop_alu sop_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .instr     (instr),
    .operand   (operand),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/sop_alu_bench.sv
module sop_alu_bench;

    localparam logic [15:0] W_CLR  = 16'o005000, B_CLR = 16'o105000;
    localparam logic [15:0] W_COM  = 16'o005100, B_COM = 16'o105100;
    localparam logic [15:0] W_INC  = 16'o005200, B_INC = 16'o105200;
    localparam logic [15:0] W_DEC  = 16'o005300, B_DEC = 16'o105300;
    localparam logic [15:0] W_NEG  = 16'o005400, B_NEG = 16'o105400;
    localparam logic [15:0] W_ADC  = 16'o005500;
    localparam logic [15:0] W_SBC  = 16'o005600;
    localparam logic [15:0] W_TST  = 16'o005700, B_TST = 16'o105700;
    localparam logic [15:0] W_ROR  = 16'o006000;
    localparam logic [15:0] W_ROL  = 16'o006100, B_ROL = 16'o106100;
    localparam logic [15:0] W_ASR  = 16'o006200, B_ASR = 16'o106200;
    localparam logic [15:0] W_ASL  = 16'o006300;
    localparam logic [15:0] W_SWAB = 16'o000300, B_SWAB = 16'o100300;
    localparam logic [15:0] W_SXT  = 16'o006700, B_SXT = 16'o106700;

    typedef struct packed {
        logic [15:0] ins;
        logic [15:0] opd;
        logic [3:0]  fin;
        logic [15:0] res;
        logic [3:0]  fo;
        logic        we;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{W_CLR,  16'h1234, 4'b1011, 16'h0000, 4'b0100, 1'b1, 8'd3},   // R3
        '{B_CLR,  16'h1234, 4'b0000, 16'h1200, 4'b0100, 1'b1, 8'd2},   // R2
        '{W_COM,  16'h00FF, 4'b0000, 16'hFF00, 4'b1001, 1'b1, 8'd4},   // R4
        '{W_COM,  16'hFFFF, 4'b0000, 16'h0000, 4'b0101, 1'b1, 8'd4},   // R4
        '{W_INC,  16'h7FFF, 4'b0001, 16'h8000, 4'b1011, 1'b1, 8'd5},   // R5
        '{W_INC,  16'hFFFF, 4'b0000, 16'h0000, 4'b0100, 1'b1, 8'd5},   // R5
        '{W_DEC,  16'h8000, 4'b0001, 16'h7FFF, 4'b0011, 1'b1, 8'd5},   // R5
        '{W_DEC,  16'h0001, 4'b0000, 16'h0000, 4'b0100, 1'b1, 8'd5},   // R5
        '{B_INC,  16'h127F, 4'b0000, 16'h1280, 4'b1010, 1'b1, 8'd2},   // R2
        '{B_DEC,  16'hAB80, 4'b0001, 16'hAB7F, 4'b0011, 1'b1, 8'd2},   // R2
        '{W_NEG,  16'h0001, 4'b0000, 16'hFFFF, 4'b1001, 1'b1, 8'd6},   // R6
        '{W_NEG,  16'h0000, 4'b1111, 16'h0000, 4'b0100, 1'b1, 8'd6},   // R6
        '{W_NEG,  16'h8000, 4'b0000, 16'h8000, 4'b1011, 1'b1, 8'd6},   // R6
        '{B_NEG,  16'h5580, 4'b0000, 16'h5580, 4'b1011, 1'b1, 8'd2},   // R2
        '{W_ADC,  16'hFFFF, 4'b0001, 16'h0000, 4'b0101, 1'b1, 8'd7},   // R7
        '{W_ADC,  16'h7FFF, 4'b0001, 16'h8000, 4'b1010, 1'b1, 8'd7},   // R7
        '{W_ADC,  16'h7FFF, 4'b0000, 16'h7FFF, 4'b0000, 1'b1, 8'd7},   // R7
        '{W_SBC,  16'h0000, 4'b0001, 16'hFFFF, 4'b1001, 1'b1, 8'd7},   // R7
        '{W_SBC,  16'h8000, 4'b0001, 16'h7FFF, 4'b0010, 1'b1, 8'd7},   // R7
        '{W_TST,  16'h8000, 4'b0111, 16'h8000, 4'b1000, 1'b0, 8'd8},   // R8
        '{B_TST,  16'h1200, 4'b1011, 16'h1200, 4'b0100, 1'b0, 8'd8},   // R8
        '{W_ROR,  16'h0001, 4'b0000, 16'h0000, 4'b0111, 1'b1, 8'd9},   // R9
        '{W_ROR,  16'h0002, 4'b0001, 16'h8001, 4'b1010, 1'b1, 8'd9},   // R9
        '{W_ROL,  16'h8000, 4'b0000, 16'h0000, 4'b0111, 1'b1, 8'd9},   // R9
        '{B_ROL,  16'h3480, 4'b0001, 16'h3401, 4'b0011, 1'b1, 8'd2},   // R2
        '{W_ASR,  16'h8001, 4'b0000, 16'hC000, 4'b1001, 1'b1, 8'd10},  // R10
        '{W_ASR,  16'h0001, 4'b0000, 16'h0000, 4'b0111, 1'b1, 8'd10},  // R10
        '{W_ASL,  16'h4000, 4'b0000, 16'h8000, 4'b1010, 1'b1, 8'd11},  // R11
        '{W_ASL,  16'hC000, 4'b0000, 16'h8000, 4'b1001, 1'b1, 8'd11},  // R11
        '{B_ASR,  16'h0081, 4'b0000, 16'h00C0, 4'b1001, 1'b1, 8'd2},   // R2
        '{W_SWAB, 16'h1280, 4'b0011, 16'h8012, 4'b0000, 1'b1, 8'd12},  // R12
        '{W_SWAB, 16'h00FF, 4'b0000, 16'hFF00, 4'b0100, 1'b1, 8'd12},  // R12
        '{W_SXT,  16'h1234, 4'b1000, 16'hFFFF, 4'b1000, 1'b1, 8'd13},  // R13
        '{W_SXT,  16'h1234, 4'b0011, 16'h0000, 4'b0101, 1'b1, 8'd13},  // R13
        '{B_SWAB, 16'h1234, 4'b0101, 16'h1234, 4'b0101, 1'b0, 8'd14},  // R14
        '{B_SXT,  16'h1234, 4'b1000, 16'h1234, 4'b1000, 1'b0, 8'd14},  // R14
        '{16'o010000, 16'h5555, 4'b0110, 16'h5555, 4'b0110, 1'b0, 8'd1}, // R1
        '{16'o005037, 16'h0005, 4'b0000, 16'h0000, 4'b0100, 1'b1, 8'd1}, // R1
        '{B_COM,  16'h12F0, 4'b0000, 16'h120F, 4'b0001, 1'b1, 8'd2}    // R2
    };

    logic        clk = 1'b0;
    logic [15:0] instr;
    logic [15:0] operand;
    logic [3:0]  flags_in;
    logic [15:0] result;
    logic [3:0]  flags_out;
    logic        wr_en;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sop_alu u_sop_alu (
        .instr     (instr),
        .operand   (operand),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .wr_en     (wr_en)
    );

    task automatic apply(input logic [15:0] i, input logic [15:0] d, input logic [3:0] f);
        @(posedge clk);
        instr    = i;
        operand  = d;
        flags_in = f;
        @(negedge clk);
    endtask

    task automatic expect_out(input int req, input logic [15:0] r, input logic [3:0] fo, input logic we);
        checks++;
        if (result !== r || flags_out !== fo || wr_en !== we) begin
            failures++;
            $display("FAIL R%0d instr=%o: got res=%h nzvc=%b we=%b, expected res=%h nzvc=%b we=%b",
                     req, instr, result, flags_out, wr_en, r, fo, we);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        instr    = 16'o000000;
        operand  = 16'h0000;
        flags_in = 4'b0000;

        // Idle state: a halt word is not owned by the block (R1)
        apply(16'o000000, 16'hABCD, 4'b1010);
        expect_out(1, 16'hABCD, 4'b1010, 1'b0);

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k].ins, VECS[k].opd, VECS[k].fin);
            expect_out(int'(VECS[k].req), VECS[k].res, VECS[k].fo, VECS[k].we);
        end

        // Directed corners
        // R7: byte add carry at 0xFF with a live upper byte
        apply(16'o105500, 16'h9AFF, 4'b0001);
        expect_out(7, 16'h9A00, 4'b0101, 1'b1);
        // R7: byte subtract carry at 0x80
        apply(16'o105600, 16'h6680, 4'b0001);
        expect_out(7, 16'h667F, 4'b0010, 1'b1);
        // R9: byte rotate right takes carry into bit 7
        apply(16'o106000, 16'hFF02, 4'b0001);
        expect_out(9, 16'hFF81, 4'b1010, 1'b1);
        // R10: byte shift left out of bit 7
        apply(16'o106300, 16'h0140, 4'b0000);
        expect_out(10, 16'h0180, 4'b1010, 1'b1);
        // R1: code just past the owned range
        apply(16'o006400, 16'h0F0F, 4'b1001);
        expect_out(1, 16'h0F0F, 4'b1001, 1'b0);

        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            report();
        end
    end

endmodule